// File: doc/BRIEF.md
# Hold-Off Gated Event Poster

Firmware posts sound-event codes through a byte-wide register port, and this block forwards each accepted code to a downstream event queue. The code is a 7-bit field. The queue entry it produces is that code with a fixed offset of 80h added, so entries fall in the range 80h to FFh. Each entry is offered on a valid/ready handshake and is held until the queue takes it.

A programmable hold-off sets the rate at which firmware may post. The hold-off is loaded from a timeout register whose unit is one second. A prescaler divides the system clock down to one-second ticks. While the hold-off runs, or while an entry is still waiting for the queue, the trigger register reports not-ready, and any write to it is discarded. Firmware is expected to poll the ready bit before it posts. An enable input chooses whether the hold-off applies at all. That input comes from a separate input-property register.

Top module: `evt_trig_gate`

## Requirements
- R1: After reset, the timeout register reads 00h, the trigger register reads 80h (ready bit 7 set, code 0), and `evtValid` is low.
- R2: Address 0 is the 8-bit read/write timeout register. Address 1 is the trigger register. Any other address reads 00h.
- R3: A trigger write made while ready is high raises `evtValid` on the next cycle. A push only ever follows such a write.
- R4: While `evtValid` is high and `evtReady` is low, `evtValid` and `evtVector` hold. The ready bit reads 0 until the queue accepts the entry.
- R5: A trigger write made while the ready bit is 0 is dropped. No entry is pushed, and the code read back at address 1 keeps its earlier value.
- R6: If hold-off is enabled and the timeout is T (nonzero), the ready bit reads 0 for exactly T × TICKS_PER_SEC clock cycles after the accepting edge, provided the entry has been taken. It then reads 1.
- R7: If the timeout is 00h, or hold-off is disabled, the ready bit returns to 1 on the cycle after the queue takes the entry.
- R8: Dropping `holdEnable` during a running hold-off ends it. The ready bit reads 1 on the next cycle.
- R9: `evtVector` equals 80h plus bits 6:0 of the accepted write. Bit 7 of the write data has no effect. Code 00h yields 80h and code 7Fh yields FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address |
| regWdata | input | DATA_W | Register write data |
| regRdata | output | DATA_W | Register read data (combinational) |
| holdEnable | input | 1 | Hold-off enable from input-property register |
| evtValid | output | 1 | Queue entry valid |
| evtVector | output | DATA_W | Queue entry (80h + code) |
| evtReady | input | 1 | Queue can accept the entry |

## Verification
The push path is tried with three kinds of codes. The extreme codes 00h and 7Fh separate a true 80h offset from a plain copy or a truncation. A write with bit 7 set shows that this bit does not leak into the entry. Back-pressure with `evtReady` held low separates a held entry from one that is lost or overwritten when a second write arrives. The hold-off is measured at its last blocked cycle and at its first free cycle, which catches an off-by-one tick. The zero-timeout case and the disabled case each show that the ready bit depends only on the queue handshake. Dropping the enable in the middle of a hold-off shows that the hold-off ends at once.

// File: rtl/evt_trig_pkg.sv
package evt_trig_pkg;
  typedef struct packed {
    logic storeCode;  // latch a new event code
    logic loadTimer;  // load second counter and clear prescaler
    logic runTimer;   // hold-off in progress
  } trigStrobe_t;
endpackage

// File: rtl/evt_trig_ctrl.sv
module evt_trig_ctrl
  import evt_trig_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              holdEnable,
  input  logic              timeoutNonZero,
  input  logic              holdDone,
  input  logic              evtReady,
  output logic              evtValid,
  output logic              readyFlag,
  output trigStrobe_t       strb
);
  localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(1);

  logic pending;
  logic holdActive;
  logic trigWrite;
  logic accept;
  logic holdStart;

  assign readyFlag = !pending && !holdActive;
  assign trigWrite = regWe && (regAddr == TRIG_ADDR);
  assign accept    = trigWrite && readyFlag;
  assign holdStart = accept && holdEnable && timeoutNonZero;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending    <= 1'b0;
      holdActive <= 1'b0;
    end else begin
      if (accept)        pending <= 1'b1;
      else if (evtReady) pending <= 1'b0;

      if (!holdEnable)    holdActive <= 1'b0;
      else if (holdStart) holdActive <= 1'b1;
      else if (holdDone)  holdActive <= 1'b0;
    end
  end

  always_comb begin
    strb.storeCode = accept;
    strb.loadTimer = holdStart;
    strb.runTimer  = holdActive;
  end

  assign evtValid = pending;
endmodule

// File: rtl/evt_trig_dp.sv
module evt_trig_dp
  import evt_trig_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 2,
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  input  logic              readyFlag,
  input  trigStrobe_t       strb,
  output logic [DATA_W-1:0] regRdata,
  output logic [DATA_W-1:0] evtVector,
  output logic              timeoutNonZero,
  output logic              holdDone
);
  localparam int CODE_W = DATA_W - 1;
  localparam int PRE_W  = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
  localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICKS_PER_SEC - 1);
  localparam logic [ADDR_W-1:0] TO_ADDR   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(1);
  localparam logic [DATA_W-1:0] VEC_BASE  = DATA_W'(1) << CODE_W;

  logic [DATA_W-1:0] timeoutReg;
  logic [CODE_W-1:0] codeReg;
  logic [PRE_W-1:0]  preCnt;
  logic [DATA_W-1:0] secLeft;
  logic              secTick;

  assign secTick        = strb.runTimer && (preCnt == PRE_LAST);
  assign holdDone       = secTick && (secLeft == DATA_W'(1));
  assign timeoutNonZero = (timeoutReg != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeoutReg <= '0;
      codeReg    <= '0;
      preCnt     <= '0;
      secLeft    <= '0;
    end else begin
      if (regWe && regAddr == TO_ADDR) timeoutReg <= regWdata;
      if (strb.storeCode)              codeReg    <= regWdata[CODE_W-1:0];

      if (strb.loadTimer) begin
        preCnt  <= '0;
        secLeft <= timeoutReg;
      end else if (strb.runTimer) begin
        if (secTick) begin
          preCnt  <= '0;
          secLeft <= secLeft - DATA_W'(1);
        end else begin
          preCnt <= preCnt + PRE_W'(1);
        end
      end
    end
  end

  assign evtVector = VEC_BASE + DATA_W'(codeReg);

  always_comb begin
    if (regAddr == TO_ADDR)        regRdata = timeoutReg;
    else if (regAddr == TRIG_ADDR) regRdata = {readyFlag, codeReg};
    else                           regRdata = '0;
  end
endmodule

// File: rtl/evt_trig_gate.sv
module evt_trig_gate
  import evt_trig_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int ADDR_W        = 2,
  parameter int TICKS_PER_SEC = 50_000_000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              holdEnable,
  output logic              evtValid,
  output logic [DATA_W-1:0] evtVector,
  input  logic              evtReady
);
  trigStrobe_t strb;
  logic readyFlag;
  logic timeoutNonZero;
  logic holdDone;

  evt_trig_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .holdEnable(holdEnable), .timeoutNonZero(timeoutNonZero),
    .holdDone(holdDone), .evtReady(evtReady), .evtValid(evtValid),
    .readyFlag(readyFlag), .strb(strb)
  );

  evt_trig_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TICKS_PER_SEC(TICKS_PER_SEC)) u_dp (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .readyFlag(readyFlag), .strb(strb),
    .regRdata(regRdata), .evtVector(evtVector),
    .timeoutNonZero(timeoutNonZero), .holdDone(holdDone)
  );
endmodule

// File: rtl/evt_trig_chk.sv
module evt_trig_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              holdEnable,
  input logic              evtValid,
  input logic              evtReady,
  input logic [DATA_W-1:0] evtVector,
  input logic              readyFlag
);
  localparam logic [ADDR_W-1:0] TRIG_ADDR = ADDR_W'(1);

  a_r3_push_needs_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtValid) |-> $past(regWe && regAddr == TRIG_ADDR));

  a_r4_entry_held: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady) |=> (evtValid && $stable(evtVector)));

  a_r5_busy_write_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == TRIG_ADDR && !readyFlag && !evtValid) |=> !evtValid);

  a_r8_disable_frees: assert property (@(posedge clk) disable iff (!rstN)
    !holdEnable |=> (evtValid || readyFlag));

  a_r9_vector_range: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> evtVector[DATA_W-1]);
endmodule

bind evt_trig_gate evt_trig_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .holdEnable(holdEnable), .evtValid(evtValid), .evtReady(evtReady),
  .evtVector(evtVector), .readyFlag(readyFlag)
);

// File: tb/test_evt_trig_gate.sv
module test_evt_trig_gate;
  localparam int CLK_PERIOD = 10;
  localparam int TPS        = 8;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic       holdEnable = 1'b0;
  logic       evtValid;
  logic [7:0] evtVector;
  logic       evtReady = 1'b1;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_trig_gate #(.DATA_W(8), .ADDR_W(2), .TICKS_PER_SEC(TPS)) i_evt_trig_gate (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .holdEnable(holdEnable),
    .evtValid(evtValid), .evtVector(evtVector), .evtReady(evtReady)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); check("R1 timeout reset", d, 8'h00);
    rd(2'd1, d); check("R1 trigger reset", d, 8'h80);
    check("R1 valid reset", {7'b0, evtValid}, 8'h00);
  endtask

  task automatic t_regs();
    logic [7:0] d;
    wr(2'd0, 8'hA5); rd(2'd0, d); check("R2 timeout rw", d, 8'hA5);
    rd(2'd2, d); check("R2 unmapped read", d, 8'h00);
    rd(2'd3, d); check("R2 unmapped read", d, 8'h00);
    wr(2'd0, 8'h00); rd(2'd0, d); check("R2 timeout rw zero", d, 8'h00);
  endtask

  task automatic t_push();
    logic [7:0] d;
    holdEnable = 1'b0; evtReady = 1'b1;
    wr(2'd1, 8'hFF);
    check("R3 valid after write", {7'b0, evtValid}, 8'h01);
    check("R9 code 7F vector", evtVector, 8'hFF);
    cyc(1);
    check("R7 valid consumed", {7'b0, evtValid}, 8'h00);
    rd(2'd1, d); check("R7 ready back", d, 8'hFF);
    wr(2'd1, 8'h80);
    check("R9 code 00 vector bit7 ignored", evtVector, 8'h80);
    wr(2'd1, 8'hD5);
    check("R9 code 55 vector", evtVector, 8'hD5);
    cyc(1);
  endtask

  task automatic t_backpressure();
    logic [7:0] d;
    holdEnable = 1'b0; evtReady = 1'b0;
    wr(2'd1, 8'h05);
    rd(2'd1, d); check("R4 ready low while pending", d, 8'h05);
    wr(2'd1, 8'h06);
    rd(2'd1, d); check("R5 dropped code kept", d, 8'h05);
    cyc(3);
    check("R4 valid held", {7'b0, evtValid}, 8'h01);
    check("R4 vector held", evtVector, 8'h85);
    evtReady = 1'b1;
    cyc(1);
    check("R4 valid cleared on accept", {7'b0, evtValid}, 8'h00);
    rd(2'd1, d); check("R4 ready after accept", d, 8'h85);
  endtask

  task automatic t_holdoff();
    logic [7:0] d;
    holdEnable = 1'b1; evtReady = 1'b1;
    wr(2'd0, 8'd3);
    wr(2'd1, 8'h12);                      // accepting edge E
    wr(2'd1, 8'h33);                      // now at E+2, dropped
    check("R5 no push during hold", {7'b0, evtValid}, 8'h00);
    cyc(3*TPS - 1 - 2);                   // E + 3*TPS - 1
    rd(2'd1, d); check("R6 still blocked last cycle", d, 8'h12);
    cyc(1);                               // E + 3*TPS
    rd(2'd1, d); check("R6 ready after hold", d, 8'h92);
  endtask

  task automatic t_zero();
    logic [7:0] d;
    holdEnable = 1'b1; evtReady = 1'b1;
    wr(2'd0, 8'd0);
    wr(2'd1, 8'h21);
    rd(2'd1, d); check("R7 pending blocks", d, 8'h21);
    cyc(1);
    rd(2'd1, d); check("R7 zero timeout ready", d, 8'hA1);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    holdEnable = 1'b1; evtReady = 1'b1;
    wr(2'd0, 8'd3);
    wr(2'd1, 8'h44);
    cyc(1);
    rd(2'd1, d); check("R6 hold running", d, 8'h44);
    holdEnable = 1'b0;
    cyc(1);
    rd(2'd1, d); check("R8 disable ends hold", d, 8'hC4);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    t_reset();
    t_regs();
    t_push();
    t_backpressure();
    t_holdoff();
    t_zero();
    t_disable();
    cyc(2);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule